// File: doc/BRIEF.md
# Local Countdown Timer with Vector Entry

This block is a per-processor 32-bit countdown timer. Software programs it through a small register port. It writes a timer vector entry, a divide setting and a start count. The counter then steps down once every 2^shift clock cycles. When it reaches zero it raises a one-cycle vector request, unless the entry's mask bit blocks it.

The entry selects one of two modes. In one-shot mode the counter halts at zero. In periodic mode it reloads the start count on the tick after zero. The running count can be read back at any time. A start count of zero keeps the timer idle.

The vector output is a plain strobe with no ready input and no back-pressure. `vec_valid` is high for exactly one cycle per expiry, and the receiver must capture `vec_num` in that cycle. A following expiry can come no sooner than the next tick. That gap is at least one cycle at divide-by-1.

Top module: `cdown_timer`

## Requirements
- R1: Register select codes are: 0 = timer entry, 1 = start count, 2 = current count, 3 = divide setting. A divide write keeps only `wr_data` bits 0, 1 and 3, and bit 2 always reads back as 0.
- R2: The divide code is {bit3, bit1, bit0} and the shift is (code + 1) mod 8. The count steps down once every 2^shift cycles, so code 111 divides by 1 and code 110 divides by 128.
- R3: A start-count write loads the counter with the written value and restarts the prescaler. After k further clock edges the count reads start − floor(k / 2^shift), until it reaches zero.
- R4: In one-shot mode (entry bit 17 = 0) the count steps down to 0 and stays there, with exactly one expiry.
- R5: In periodic mode (entry bit 17 = 1) the count cycles through start+1 values (start, …, 1, 0) and reloads the start count on the tick after 0. There is one expiry per cycle.
- R6: An expiry happens on the tick that moves the count from 1 to 0. If entry bit 16 (mask) is clear, `vec_valid` is high for exactly one cycle, in the cycle the count first reads 0, and `vec_num` equals entry bits 7:0. If the mask bit is set, there is no request.
- R7: A start count of 0 leaves the timer stopped at 0 and produces no expiry.
- R8: An entry write re-evaluates the schedule. A stopped one-shot timer with a non-zero start count, once switched to periodic, reloads on the next tick and runs again.
- R9: The current-count register is read-only. A write to it leaves the count and the start count unchanged.
- R10: If a start-count write falls in the same cycle as the tick that would expire the timer, the write wins. The timer reloads and no request is raised.
- R11: After reset the entry reads 0x0001_0000 (masked, one-shot, vector 0), the start count, current count and divide setting read 0, and `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selected for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Register selected for the read |
| rd_data | output | 32 | Read data (combinational) |
| vec_valid | output | 1 | One-cycle expiry request |
| vec_num | output | 8 | Vector number of the request |

## Verification
Two things can land in the same cycle: a register write and the tick that ends a countdown. The bench arms the timer at divide-by-1 with a start count of 2. It then issues a second start-count write timed to hit the very edge on which the count would go from 1 to 0. The pass criterion is that the counter shows the new start value, minus later ticks, and that no request pulse is ever seen. A second overlap occurs when an entry write meets a stopped one-shot timer, and the bench judges it by the reload value on the next tick.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_ENTRY = 2'd0,
    SEL_START = 2'd1,
    SEL_CUR   = 2'd2,
    SEL_DIV   = 2'd3
  } cdt_sel_e;

  localparam int MASK_BIT     = 16;
  localparam int PERIODIC_BIT = 17;
  localparam logic [3:0] DIV_KEEP = 4'hB;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] presc_q;
  logic [PRE_W:0]   lim;

  always_comb begin
    lim  = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
    tick = ({1'b0, presc_q} >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr || tick) presc_q <= '0;
    else                       presc_q <= presc_q + 1'b1;
  end

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && shift != '0) |=> (!tick || shift != $past(shift)));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_val,
  input  logic             entry_wr,
  input  logic             periodic_new,
  input  logic             periodic,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cur_d;

  always_comb begin
    cur_d  = cur_q;
    run_d  = run_q;
    expire = 1'b0;
    if (tick && run_q) begin
      if (cur_q == '0) begin
        if (periodic) cur_d = start_q;
        else          run_d = 1'b0;
      end else begin
        cur_d = cur_q - 1'b1;
        if (cur_q == CNT_W'(1)) begin
          expire = 1'b1;
          if (!periodic) run_d = 1'b0;
        end
      end
    end
    if (entry_wr)
      run_d = (start_q != '0) && (periodic_new || cur_d != '0);
    if (start_wr) begin
      cur_d  = start_val;
      run_d  = (start_val != '0);
      expire = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      cur_q   <= '0;
      run_q   <= 1'b0;
    end else begin
      if (start_wr) start_q <= start_val;
      cur_q <= cur_d;
      run_q <= run_d;
    end
  end

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> (cur_q == $past(start_val)));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_wr) |=> (cur_q == $past(cur_q)));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_q && cur_q != '0 && !start_wr) |=> (cur_q == $past(cur_q) - 1'b1));
endmodule

// File: rtl/cdt_expiry.sv
module cdt_expiry #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             mask,
  input  logic [VEC_W-1:0] vector,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_num
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_num   <= '0;
    end else begin
      vec_valid <= expire && !mask;
      if (expire && !mask) vec_num <= vector;
    end
  end

  // R6
  fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !mask) |=> (vec_valid && vec_num == $past(vector)));
  // R6
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire || mask) |=> !vec_valid);
endmodule

// File: rtl/cdown_timer.sv
module cdown_timer #(
  parameter int CNT_W   = 32,
  parameter int VEC_W   = 8,
  parameter int SHIFT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_num
);
  import cdt_pkg::*;

  logic             periodic_q, mask_q;
  logic [VEC_W-1:0] vector_q;
  logic [3:0]       div_q;
  logic [SHIFT_W-1:0] shift;
  logic             tick, expire, start_wr, entry_wr;
  logic [CNT_W-1:0] start_q, cur_q;

  assign start_wr = wr_en && (wr_sel == SEL_START);
  assign entry_wr = wr_en && (wr_sel == SEL_ENTRY);
  assign shift    = SHIFT_W'({div_q[3], div_q[1:0]} + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodic_q <= 1'b0;
      mask_q     <= 1'b1;
      vector_q   <= '0;
      div_q      <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ENTRY) begin
        periodic_q <= wr_data[PERIODIC_BIT];
        mask_q     <= wr_data[MASK_BIT];
        vector_q   <= wr_data[VEC_W-1:0];
      end
      if (wr_sel == SEL_DIV) div_q <= wr_data[3:0] & DIV_KEEP;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ENTRY: begin
        rd_data[VEC_W-1:0]   = vector_q;
        rd_data[MASK_BIT]     = mask_q;
        rd_data[PERIODIC_BIT] = periodic_q;
      end
      SEL_START: rd_data = start_q;
      SEL_CUR:   rd_data = cur_q;
      default:   rd_data[3:0] = div_q;
    endcase
  end

  cdt_prescaler #(.SHIFT_W(SHIFT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clr(start_wr), .shift(shift), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start_wr(start_wr), .start_val(wr_data),
    .entry_wr(entry_wr), .periodic_new(wr_data[PERIODIC_BIT]),
    .periodic(periodic_q), .start_q(start_q), .cur_q(cur_q), .expire(expire)
  );

  cdt_expiry #(.VEC_W(VEC_W)) u_exp (
    .clk(clk), .rst_n(rst_n), .expire(expire), .mask(mask_q),
    .vector(vector_q), .vec_valid(vec_valid), .vec_num(vec_num)
  );

  // R9
  cur_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_CUR) |=> (start_q == $past(start_q)));
endmodule

// File: tb/cdown_timer_tb.sv
module cdown_timer_tb;
  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        vec_valid;
  logic [7:0]  vec_num;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  logic [7:0] last_vec = '0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  cdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .vec_valid(vec_valid), .vec_num(vec_num)
  );

  always @(negedge clk) if (rst_n && vec_valid) begin
    pulses++;
    last_vec = vec_num;
  end

  // row: {divide, entry, start, wait edges, expected current}
  localparam logic [115:0] VECS [8] = '{
    {4'hB, 32'h0001_0000, 32'd10,  16'd4,   32'd6},
    {4'h0, 32'h0001_0000, 32'd10,  16'd6,   32'd7},
    {4'h1, 32'h0001_0000, 32'd100, 16'd12,  32'd97},
    {4'h8, 32'h0001_0000, 32'd5,   16'd64,  32'd3},
    {4'hA, 32'h0001_0000, 32'd2,   16'd256, 32'd0},
    {4'h4, 32'h0001_0000, 32'd20,  16'd8,   32'd16},
    {4'hB, 32'h0001_0000, 32'd3,   16'd10,  32'd0},
    {4'hB, 32'h0003_0000, 32'd3,   16'd5,   32'd2}
  };
  localparam string VTAG [8] = '{"R2", "R2", "R2", "R2", "R2", "R1", "R4", "R5"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wait_e(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, v); chk("R11 entry", v, 32'h0001_0000);
    rd(2'd1, v); chk("R11 start", v, 32'h0);
    rd(2'd2, v); chk("R11 current", v, 32'h0);
    rd(2'd3, v); chk("R11 divide", v, 32'h0);
    chk("R11 vec_valid", {31'b0, vec_valid}, 32'h0);

    // table walk: R1 R2 R4 R5
    foreach (VECS[i]) begin
      wr(2'd0, VECS[i][111:80]);
      wr(2'd3, {28'b0, VECS[i][115:112]});
      wr(2'd1, VECS[i][79:48]);
      wait_e(int'(VECS[i][47:32]));
      rd(2'd2, v);
      chk(VTAG[i], v, VECS[i][31:0]);
    end

    // R1 divide readback drops bit 2
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R1 readback", v, 32'hB);

    // R6 unmasked one-shot expiry timing and vector
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h0000_005A);
    wr(2'd3, 32'hB);
    pulses = 0;
    wr(2'd1, 32'd3);
    wait_e(2);
    chk("R6 no early pulse", {31'b0, vec_valid}, 32'h0);
    wait_e(1);
    rd(2'd2, v); chk("R6 count zero", v, 32'h0);
    chk("R6 pulse", {31'b0, vec_valid}, 32'h1);
    chk("R6 vector", {24'b0, vec_num}, 32'h5A);
    wait_e(1);
    chk("R6 single cycle", {31'b0, vec_valid}, 32'h0);
    wait_e(10);
    rd(2'd2, v); chk("R4 stays zero", v, 32'h0);
    chk("R4 one expiry", pulses, 1);

    // R6 masked
    wr(2'd0, 32'h0001_005A);
    pulses = 0;
    wr(2'd1, 32'd3);
    wait_e(10);
    rd(2'd2, v);
    chk("R6 masked none", pulses, 0);

    // R5 periodic pulse count
    wr(2'd0, 32'h0002_0033);
    pulses = 0;
    wr(2'd1, 32'd2);
    wait_e(12);
    rd(2'd2, v);
    chk("R5 periodic pulses", pulses, 4);
    chk("R5 vector", {24'b0, last_vec}, 32'h33);

    // R7 zero start
    wr(2'd1, 32'd0);
    pulses = 0;
    wait_e(20);
    rd(2'd2, v); chk("R7 current", v, 32'h0);
    chk("R7 no expiry", pulses, 0);

    // R9 current count is read-only
    wr(2'd3, 32'hA);
    wr(2'd1, 32'd1000);
    wr(2'd2, 32'h1234);
    rd(2'd2, v); chk("R9 current", v, 32'd1000);
    rd(2'd1, v); chk("R9 start", v, 32'd1000);

    // R3 restart on start write
    wr(2'd3, 32'hB);
    wr(2'd1, 32'd10);
    wait_e(5);
    rd(2'd2, v); chk("R3 before restart", v, 32'd5);
    wr(2'd1, 32'd10);
    wait_e(2);
    rd(2'd2, v); chk("R3 after restart", v, 32'd8);

    // R10 start write collides with expiring tick
    wr(2'd0, 32'h0000_0044);
    wr(2'd1, 32'd0);
    pulses = 0;
    wr(2'd1, 32'd2);
    wr(2'd1, 32'd5);
    rd(2'd2, v); chk("R10 reload wins", v, 32'd5);
    wait_e(2);
    rd(2'd2, v); chk("R10 continues", v, 32'd3);
    chk("R10 no pulse", pulses, 0);

    // R8 entry write revives stopped one-shot
    wr(2'd0, 32'h0000_0021);
    wr(2'd1, 32'd2);
    wait_e(5);
    rd(2'd2, v); chk("R8 stopped", v, 32'h0);
    pulses = 0;
    wr(2'd0, 32'h0002_0021);
    rd(2'd2, v); chk("R8 still zero", v, 32'h0);
    wait_e(1);
    rd(2'd2, v); chk("R8 reloaded", v, 32'd2);
    wait_e(2);
    rd(2'd2, v); chk("R8 expired again", v, 32'h0);
    chk("R8 pulse", pulses, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule